// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block takes over refresh duty for a DRAM once the device initialization sequence has completed. An interval timer spreads auto-refresh commands evenly across the retention window. The spacing is the retention time in clock cycles divided by the number of rows, so every row is refreshed in time. Each refresh is followed by a recovery window of tRFC cycles. In that window the block forbids any other command and holds the access grant low.

The block also runs the low-power handshake. A sleep request is accepted only when the access path reports idle. A refresh that is already due is issued before entry. Entry is an auto-refresh command driven together with clock-enable low, after which the clock-enable stays low and the device refreshes itself. A wake request raises clock-enable first. The block then issues only NOPs for the exit recovery time tXSR and issues one refresh right away. The interval timer restarts from that refresh. Normal accesses are granted again only after the recovery window of that refresh.

All pins are plain control and status levels or one-cycle pulses. No data stream passes through the block, so no valid/ready handshake and no back-pressure apply. `sleep_req_i` and `wake_req_i` are levels, sampled on each rising clock edge.

Top module: `dram_refresh_sr_mgr`

## Requirements
- R1: After reset and until `init_done_i` is seen high, `access_ok_o` is 0, `ref_cmd_o` is 0 and `cke_o` is 1.
- R2: With INTERVAL = RETENTION_CYC / ROW_COUNT, the first refresh pulse comes exactly INTERVAL cycles after `access_ok_o` first rises. While awake, successive refresh pulses are exactly INTERVAL cycles apart.
- R3: A refresh pulse (`ref_cmd_o` = 1 with `cke_o` = 1) lasts one cycle. `access_ok_o` is 0 in that cycle and in the next T_RFC cycles, and no command follows within them. `access_ok_o` returns to 1 on the cycle after.
- R4: A sleep request while `bus_idle_i` is 0 has no effect: `cke_o` stays 1 and periodic refresh keeps its spacing.
- R5: A sleep request with `bus_idle_i` = 1 while access is granted produces, on the next cycle, `ref_cmd_o` = 1 together with `cke_o` = 0. After that cycle `cke_o` stays 0.
- R6: If a refresh falls due in the cycle a sleep request is accepted, a normal refresh (`cke_o` = 1) is issued first. Self-refresh entry follows T_RFC + 2 cycles after that refresh.
- R7: While in self-refresh (`cke_o` = 0 after the entry cycle), `ref_cmd_o` stays 0 and `access_ok_o` stays 0 however long the stay lasts.
- R8: On a wake request, `cke_o` goes to 1 on the next cycle. For T_XSR cycles only NOPs follow (`ref_cmd_o` = 0). A refresh pulse with `cke_o` = 1 comes on the following cycle.
- R9: After wake, `access_ok_o` stays 0 until T_RFC cycles after the exit refresh, and rises on the cycle after.
- R10: The first periodic refresh after wake comes exactly INTERVAL cycles after the exit refresh.
- R11: `wake_req_i` outside self-refresh has no effect on `cke_o`, `access_ok_o` or refresh spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Device initialization sequence finished |
| sleep_req_i | input | 1 | Level request to enter self-refresh |
| wake_req_i | input | 1 | Level request to leave self-refresh |
| bus_idle_i | input | 1 | No access in flight on the DRAM command path |
| ref_cmd_o | output | 1 | Auto-refresh command this cycle (entry when `cke_o` is 0) |
| cke_o | output | 1 | DRAM clock-enable |
| access_ok_o | output | 1 | Normal read/write commands may be issued |

## Verification
The refresh scheduler is tried under three patterns. The first is a quiet run after init, which separates correct spacing from an off-by-one in the timer. The second is a run with a busy bus and a pending sleep request, which tells whether the idle gate is honoured. The third is a run with stray wake requests, which shows that they do not disturb the timer. The self-refresh handshake is tried twice. One entry comes mid-interval and checks that the entry command and the clock-enable drop share a cycle. The other lands on the exact cycle a refresh falls due, which separates a scheduler that issues the owed refresh first from one that drops it. The exit is timed cycle by cycle, so a short tXSR, a late exit refresh, a timer that is not restarted or an early access grant each show up as a count mismatch.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,  // waiting for device initialization
    ST_IDLE = 3'd1,  // normal operation, accesses granted
    ST_ARF  = 3'd2,  // auto-refresh command cycle
    ST_RFC  = 3'd3,  // refresh recovery window
    ST_SRE  = 3'd4,  // self-refresh entry cycle
    ST_SR   = 3'd5,  // in self-refresh, clock-enable low
    ST_XSR  = 3'd6   // exit recovery, NOPs only
  } srm_state_e;

endpackage

// File: rtl/srm_interval_timer.sv
module srm_interval_timer #(
  parameter int unsigned INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);

  localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // One cycle per elapsed interval
  assign tick = en && !clr && (cnt_q == LAST);

endmodule

// File: rtl/srm_wait_ctr.sv
module srm_wait_ctr #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             zero
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/srm_ctrl_fsm.sv
module srm_ctrl_fsm
  import srm_pkg::*;
#(
  parameter int unsigned T_RFC  = 6,
  parameter int unsigned T_XSR  = 10,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              bus_idle,
  input  logic              tick,
  input  logic              wait_zero,
  output logic              wait_load,
  output logic [WAIT_W-1:0] wait_val,
  output logic              timer_en,
  output logic              timer_clr,
  output logic              ref_cmd,
  output logic              cke,
  output logic              access_ok
);

  localparam logic [WAIT_W-1:0] RFC_LOAD = WAIT_W'(T_RFC - 1);
  localparam logic [WAIT_W-1:0] XSR_LOAD = WAIT_W'(T_XSR - 1);

  srm_state_e state_q, state_d;
  logic       pending_q, pending_d;
  logic       ref_due;

  assign ref_due = tick || pending_q;

  always_comb begin
    state_d   = state_q;
    wait_load = 1'b0;
    wait_val  = RFC_LOAD;
    unique case (state_q)
      ST_INIT: if (init_done) state_d = ST_IDLE;
      ST_IDLE: begin
        // an owed refresh always goes out before self-refresh entry
        if (ref_due)                    state_d = ST_ARF;
        else if (sleep_req && bus_idle) state_d = ST_SRE;
      end
      ST_ARF: begin
        wait_load = 1'b1;
        wait_val  = RFC_LOAD;
        state_d   = ST_RFC;
      end
      ST_RFC:  if (wait_zero) state_d = ST_IDLE;
      ST_SRE:  state_d = ST_SR;
      ST_SR: begin
        if (wake_req) begin
          wait_load = 1'b1;
          wait_val  = XSR_LOAD;
          state_d   = ST_XSR;
        end
      end
      ST_XSR:  if (wait_zero) state_d = ST_ARF;
      default: state_d = ST_INIT;
    endcase
  end

  always_comb begin
    pending_d = pending_q;
    if (state_q inside {ST_ARF, ST_SRE, ST_SR, ST_XSR}) pending_d = 1'b0;
    if (tick) pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      pending_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
    end
  end

  assign timer_en  = state_q inside {ST_IDLE, ST_ARF, ST_RFC};
  assign timer_clr = state_q inside {ST_INIT, ST_SRE, ST_SR, ST_XSR};
  assign ref_cmd   = state_q inside {ST_ARF, ST_SRE};
  assign cke       = !(state_q inside {ST_SRE, ST_SR});
  assign access_ok = (state_q == ST_IDLE);

endmodule

// File: rtl/dram_refresh_sr_mgr.sv
module dram_refresh_sr_mgr #(
  parameter int unsigned RETENTION_CYC = 8192,
  parameter int unsigned ROW_COUNT     = 128,
  parameter int unsigned T_RFC         = 6,
  parameter int unsigned T_XSR         = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic bus_idle_i,
  output logic ref_cmd_o,
  output logic cke_o,
  output logic access_ok_o
);

  localparam int unsigned INTERVAL = RETENTION_CYC / ROW_COUNT;
  localparam int unsigned WAIT_MAX = (T_RFC > T_XSR) ? T_RFC : T_XSR;
  localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);

  logic              tick;
  logic              timer_en, timer_clr;
  logic              wait_load, wait_zero;
  logic [WAIT_W-1:0] wait_val;

  srm_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (timer_en),
    .clr   (timer_clr),
    .tick  (tick)
  );

  srm_wait_ctr #(.WIDTH(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wait_load),
    .load_val (wait_val),
    .zero     (wait_zero)
  );

  srm_ctrl_fsm #(.T_RFC(T_RFC), .T_XSR(T_XSR), .WAIT_W(WAIT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done_i),
    .sleep_req (sleep_req_i),
    .wake_req  (wake_req_i),
    .bus_idle  (bus_idle_i),
    .tick      (tick),
    .wait_zero (wait_zero),
    .wait_load (wait_load),
    .wait_val  (wait_val),
    .timer_en  (timer_en),
    .timer_clr (timer_clr),
    .ref_cmd   (ref_cmd_o),
    .cke       (cke_o),
    .access_ok (access_ok_o)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int unsigned T_RFC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic init_done_i,
  input logic ref_cmd_o,
  input logic cke_o,
  input logic access_ok_o
);

  localparam int unsigned GW = $clog2(T_RFC + 2) + 1;
  localparam logic [GW-1:0] GCAP = GW'(T_RFC + 1);
  localparam logic [GW-1:0] GMIN = GW'(T_RFC);

  logic          init_seen_q;
  logic          seen_ref_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_seen_q <= 1'b0;
      seen_ref_q  <= 1'b0;
      gap_q       <= '0;
    end else begin
      if (init_done_i) init_seen_q <= 1'b1;
      if (ref_cmd_o) begin
        seen_ref_q <= 1'b1;
        gap_q      <= '0;
      end else if (gap_q < GCAP) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  no_grant_before_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok_o |-> (init_seen_q || init_done_i));

  // R3
  ref_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd_o |=> (!access_ok_o && !ref_cmd_o));

  // R3
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd_o && seen_ref_q) |-> (gap_q >= GMIN));

  // R5
  entry_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (ref_cmd_o && !access_ok_o));

  // R7
  quiet_in_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && !$past(cke_o)) |-> (!ref_cmd_o && !access_ok_o));

  // R8
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (!ref_cmd_o && !access_ok_o));

  // R9
  grant_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok_o |-> cke_o);

endmodule

bind dram_refresh_sr_mgr srm_checker #(.T_RFC(T_RFC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_done_i (init_done_i),
  .ref_cmd_o   (ref_cmd_o),
  .cke_o       (cke_o),
  .access_ok_o (access_ok_o)
);

// File: tb/dram_refresh_sr_mgr_tb.sv
module dram_refresh_sr_mgr_tb_top;

  localparam int RET   = 8192;
  localparam int ROWS  = 128;
  localparam int TRFC  = 6;
  localparam int TXSR  = 10;
  localparam int INTV  = RET / ROWS;

  logic clk = 1'b0;
  logic rst_n;
  logic init_done, sleep_req, wake_req, bus_idle;
  logic ref_cmd, cke, access_ok;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dram_refresh_sr_mgr #(
    .RETENTION_CYC(RET), .ROW_COUNT(ROWS), .T_RFC(TRFC), .T_XSR(TXSR)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done_i (init_done),
    .sleep_req_i (sleep_req),
    .wake_req_i  (wake_req),
    .bus_idle_i  (bus_idle),
    .ref_cmd_o   (ref_cmd),
    .cke_o       (cke),
    .access_ok_o (access_ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Waits negedges until ref_cmd is seen; returns number of edges waited
  task automatic wait_ref(output int k, output int cke_low);
    k = 0;
    cke_low = 0;
    do begin
      @(negedge clk);
      k++;
      if (!cke) cke_low++;
    end while (!ref_cmd && k < 4 * INTV);
  endtask

  task automatic t_reset();
    int bad = 0;
    rst_n = 1'b0; init_done = 1'b0; sleep_req = 1'b0;
    wake_req = 1'b0; bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2 * INTV; i++) begin
      @(negedge clk);
      if (access_ok || ref_cmd || !cke) bad++;
    end
    // R1: nothing happens before init_done
    chk("R1", "outputs wrong before init", bad, 0);
    chk("R1", "cke before init", int'(cke), 1);
  endtask

  task automatic t_init_periodic();
    int k, lo, bad;
    init_done = 1'b1;
    @(negedge clk);
    chk("R2", "access_ok after init", int'(access_ok), 1);
    wait_ref(k, lo);
    // R2: first refresh INTERVAL cycles after grant
    chk("R2", "first refresh delay", k, INTV);
    chk("R3", "cke during refresh", int'(cke), 1);
    for (int rep = 0; rep < 2; rep++) begin
      bad = 0;
      for (int i = 0; i < TRFC; i++) begin
        @(negedge clk);
        if (access_ok || ref_cmd) bad++;
      end
      chk("R3", "grant/command inside tRFC", bad, 0);
      @(negedge clk);
      chk("R3", "access_ok after tRFC", int'(access_ok), 1);
      wait_ref(k, lo);
      chk("R2", "refresh spacing", k + TRFC + 1, INTV);
    end
  endtask

  task automatic t_wake_ignored();
    int k, lo, bad = 0;
    repeat (TRFC + 2) @(negedge clk);
    wake_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!cke || !access_ok) bad++;
    end
    wake_req = 1'b0;
    // R11: stray wake does nothing
    chk("R11", "stray wake changed outputs", bad, 0);
    wait_ref(k, lo);
    chk("R11", "spacing with stray wake", k + TRFC + 12, INTV);
  endtask

  task automatic t_sleep_busy();
    int k, lo;
    repeat (TRFC + 5) @(negedge clk);
    sleep_req = 1'b1; bus_idle = 1'b0;
    wait_ref(k, lo);
    // R4: busy bus blocks entry
    chk("R4", "cke low cycles while busy", lo, 0);
    chk("R4", "spacing while busy", k + TRFC + 5, INTV);
    chk("R4", "refresh has cke high", int'(cke), 1);
    sleep_req = 1'b0; bus_idle = 1'b1;
  endtask

  task automatic hold_sr(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ref_cmd || access_ok || cke) bad++;
    end
    // R7: silent self-refresh
    chk("R7", "activity in self-refresh", bad, 0);
  endtask

  task automatic t_wake_exit();
    int k, lo, bad = 0;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk("R8", "cke after wake", int'(cke), 1);
    if (ref_cmd || access_ok) bad++;
    for (int i = 1; i < TXSR; i++) begin
      @(negedge clk);
      if (ref_cmd || access_ok || !cke) bad++;
    end
    chk("R8", "non-NOP in tXSR", bad, 0);
    @(negedge clk);
    chk("R8", "exit refresh", int'(ref_cmd), 1);
    chk("R8", "exit refresh cke", int'(cke), 1);
    bad = 0;
    for (int i = 0; i < TRFC; i++) begin
      @(negedge clk);
      if (access_ok) bad++;
    end
    // R9: grant only after exit refresh recovery
    chk("R9", "early grant after exit", bad, 0);
    @(negedge clk);
    chk("R9", "grant after exit", int'(access_ok), 1);
    wait_ref(k, lo);
    // R10: timer restarted at exit refresh
    chk("R10", "first periodic after exit", k + TRFC + 1, INTV);
  endtask

  task automatic t_sleep_mid();
    repeat (TRFC + 3) @(negedge clk);
    sleep_req = 1'b1; bus_idle = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    // R5: entry command with cke low
    chk("R5", "entry ref_cmd", int'(ref_cmd), 1);
    chk("R5", "entry cke", int'(cke), 0);
    hold_sr(3 * INTV);
    t_wake_exit();
  endtask

  task automatic t_sleep_at_due();
    int k = 0;
    repeat (INTV - 1) @(negedge clk);
    sleep_req = 1'b1; bus_idle = 1'b1;
    @(negedge clk);
    // R6: owed refresh comes first
    chk("R6", "refresh before entry", int'(ref_cmd), 1);
    chk("R6", "cke on owed refresh", int'(cke), 1);
    do begin
      @(negedge clk);
      k++;
    end while (cke && k < 4 * INTV);
    sleep_req = 1'b0;
    chk("R6", "entry delay after refresh", k, TRFC + 2);
    chk("R5", "entry ref_cmd after owed", int'(ref_cmd), 1);
    hold_sr(INTV / 2);
    t_wake_exit();
  endtask

  initial begin
    t_reset();
    t_init_periodic();
    t_wake_ignored();
    t_sleep_busy();
    t_sleep_mid();
    t_sleep_at_due();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule